// File: doc/BRIEF.md
# Multi-Queue Read Port Selector

This block is the read side of a device that keeps several logical queues behind a single output bus. Each queue is a small first-in first-out store inside the block. A six-bit read address picks the queue that feeds the output. Its upper three bits name a device and its lower three bits name a queue, so up to eight devices can share one address bus and each one answers only to its own strapped identity. The output works in first-word-fall-through style on one free-running clock.

Changing queues follows a fixed two-edge pipeline. The first edge after a select still delivers one more word from the old queue. The second edge delivers the head word of the new queue. Neither edge waits for read enable. Outside a switch, read enable pops one word per edge from the selected queue.

A separate strobe latches the device field of the address as the device choice for the almost-empty flag bus. A simple write path loads words into the queues.

Top module: `mq_read_port`

## Requirements
- R1: While reset is low and on the first edge after it, rdData is 0, rdValid is 0, outEnable is 0 and flagDevSel is 0. Every queue is empty and no queue is selected.
- R2: rdAddr[5:3] carries the device field and rdAddr[2:0] carries the queue field. On an edge with rdAddrEn high and rdAddr[5:3] equal to idCode, the queue field becomes the selected queue and outEnable is high after that edge. This happens whatever the value of rdEn.
- R3: On an edge with rdAddrEn high and rdAddr[5:3] not equal to idCode, the device is deselected and outEnable goes low. While deselected, rdEn has no effect: rdData and rdValid hold, and no queue loses a word.
- R4: With a queue selected and no switch in progress, an edge with rdEn high moves the head word of that queue to rdData and sets rdValid. Words leave each queue in the order they were written.
- R5: On the edge that captures a new queue select, a read with rdEn high is still served from the previously selected queue.
- R6: The first edge after a queue select places the next word of the previously selected queue on rdData, whatever the value of rdEn. If that queue is empty, or no queue was selected before, rdValid goes low.
- R7: The second edge after a queue select places the head word of the newly selected queue on rdData with rdValid high, whatever the value of rdEn.
- R8: A read from an empty queue leaves rdData unchanged and drives rdValid low. The queue's order is not disturbed, so a word written afterwards is the next one read.
- R9: On an edge with flagStrobe high, rdAddr[5:3] is captured into flagDevSel, whatever the value of idCode. rdAddr[2:0] is ignored. At all other times flagDevSel holds.
- R10: An edge with wrEn high appends wrData to the queue numbered wrQueue, unless that queue already holds DEPTH words (16 by default). In that case the word is dropped.
- R11: With no switch in progress and rdEn low, rdData and rdValid hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running read clock, rising-edge active |
| rstN | input | 1 | Active-low synchronous reset |
| idCode | input | 3 | Strapped device identity, compared with rdAddr[5:3] |
| rdAddr | input | 6 | Device field [5:3] and queue field [2:0] |
| rdAddrEn | input | 1 | Captures a queue select from rdAddr |
| rdEn | input | 1 | Read enable for the selected queue |
| flagStrobe | input | 1 | Captures rdAddr[5:3] as the flag-bus device select |
| wrEn | input | 1 | Loads wrData into queue wrQueue |
| wrQueue | input | 3 | Queue number for the load |
| wrData | input | DATA_W | Word to load |
| rdData | output | DATA_W | Registered output word |
| rdValid | output | 1 | High when rdData holds a word that was actually read |
| outEnable | output | 1 | High while this device is selected and may drive the bus |
| flagDevSel | output | 3 | Latched device select for the almost-empty flag bus |

## Verification
The assertions assume that idCode is a static strap and that every input changes only between clock edges, so that a one-cycle `$past` on the address field is meaningful. They also assume that DEPTH is a power of two, because the queue pointers wrap freely. The stimulus holds idCode fixed for the whole run and drives every input on the falling edge. It sends selects both with and without read enable, and to matching and non-matching devices, so that the switch pipeline, the deselected hold and the flag capture all occur inside those assumptions.

// File: rtl/mq_rd_pkg.sv
package mq_rd_pkg;
  localparam int QSEL_W = 3;
  localparam int DEV_W  = 3;
  localparam int ADDR_W = QSEL_W + DEV_W;
  localparam int NUM_Q  = 1 << QSEL_W;

  // Request from control to datapath for one clock edge.
  typedef struct packed {
    logic              act;   // this edge updates the output word / valid
    logic              useQ;  // a queue is named; otherwise valid drops
    logic [QSEL_W-1:0] q;     // queue to pop
  } rdStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_HEAD  = 2'd2
  } swStage_t;
endpackage

// File: rtl/mq_rd_ctrl.sv
module mq_rd_ctrl
  import mq_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DEV_W-1:0]  idCode,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              rdAddrEn,
  input  logic              rdEn,
  input  logic              flagStrobe,
  output rdStrobe_t         strobe,
  output logic              outEnable,
  output logic [DEV_W-1:0]  flagDevSel
);
  logic [QSEL_W-1:0] selQ, prevQ;
  logic              selValid, prevValid;
  swStage_t          stage;
  logic              addrMatch;

  assign addrMatch = (rdAddr[ADDR_W-1:QSEL_W] == idCode);
  assign outEnable = selValid;

  // The action taken at an edge depends only on the stage before it.
  always_comb begin
    strobe.act  = 1'b0;
    strobe.useQ = 1'b1;
    strobe.q    = selQ;
    unique case (stage)
      ST_DRAIN: begin
        strobe.act  = 1'b1;
        strobe.useQ = prevValid;
        strobe.q    = prevQ;
      end
      ST_HEAD: begin
        strobe.act  = 1'b1;
        strobe.useQ = selValid;
      end
      default: strobe.act = selValid && rdEn;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ       <= '0;
      prevQ      <= '0;
      selValid   <= 1'b0;
      prevValid  <= 1'b0;
      stage      <= ST_IDLE;
      flagDevSel <= '0;
    end else begin
      if (flagStrobe) flagDevSel <= rdAddr[ADDR_W-1:QSEL_W];
      if (rdAddrEn) begin
        if (addrMatch) begin
          prevQ     <= selQ;
          prevValid <= selValid;
          selQ      <= rdAddr[QSEL_W-1:0];
          selValid  <= 1'b1;
          stage     <= ST_DRAIN;
        end else begin
          selValid  <= 1'b0;
          stage     <= ST_IDLE;
        end
      end else begin
        unique case (stage)
          ST_DRAIN: stage <= ST_HEAD;
          ST_HEAD:  stage <= ST_IDLE;
          default:  stage <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mq_rd_datapath.sv
module mq_rd_datapath
  import mq_rd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         strobe,
  input  logic              wrEn,
  input  logic [QSEL_W-1:0] wrQueue,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] headData [NUM_Q];
  logic [NUM_Q-1:0]  notEmpty;

  for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wrPtr, rdPtr;
    logic [CNT_W-1:0]  count;
    logic              push, pop;

    assign push        = wrEn && (wrQueue == QSEL_W'(g)) && (count != CNT_W'(DEPTH));
    assign pop         = strobe.act && strobe.useQ && (strobe.q == QSEL_W'(g)) && (count != '0);
    assign notEmpty[g] = (count != '0);
    assign headData[g] = mem[rdPtr];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        count <= '0;
      end else begin
        if (push) wrPtr <= wrPtr + 1'b1;
        if (pop)  rdPtr <= rdPtr + 1'b1;
        count <= count + CNT_W'(push) - CNT_W'(pop);
      end
    end

    always_ff @(posedge clk) begin
      if (push) mem[wrPtr] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else if (strobe.act) begin
      if (strobe.useQ && notEmpty[strobe.q]) begin
        rdData  <= headData[strobe.q];
        rdValid <= 1'b1;
      end else begin
        rdValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mq_read_port.sv
module mq_read_port
  import mq_rd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        idCode,
  input  logic [5:0]        rdAddr,
  input  logic              rdAddrEn,
  input  logic              rdEn,
  input  logic              flagStrobe,
  input  logic              wrEn,
  input  logic [2:0]        wrQueue,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              outEnable,
  output logic [2:0]        flagDevSel
);
  rdStrobe_t strobe;

  mq_rd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .idCode     (idCode),
    .rdAddr     (rdAddr),
    .rdAddrEn   (rdAddrEn),
    .rdEn       (rdEn),
    .flagStrobe (flagStrobe),
    .strobe     (strobe),
    .outEnable  (outEnable),
    .flagDevSel (flagDevSel)
  );

  mq_rd_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrEn    (wrEn),
    .wrQueue (wrQueue),
    .wrData  (wrData),
    .rdData  (rdData),
    .rdValid (rdValid)
  );
endmodule

// File: rtl/mq_read_port_chk.sv
module mq_read_port_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        idCode,
  input logic [5:0]        rdAddr,
  input logic              rdAddrEn,
  input logic              flagStrobe,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              outEnable,
  input logic [2:0]        flagDevSel
);
  a_r2_select_enables: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrEn && rdAddr[5:3] == idCode) |=> outEnable);

  a_r3_mismatch_disables: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrEn && rdAddr[5:3] != idCode) |=> !outEnable);

  a_r3_deselected_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!outEnable && !rdAddrEn) |=> ($stable(rdData) && $stable(rdValid)));

  a_r8_empty_keeps_word: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdValid) |-> $stable(rdData));

  a_r9_flag_capture: assert property (@(posedge clk) disable iff (!rstN)
    flagStrobe |=> (flagDevSel == $past(rdAddr[5:3])));

  a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
    !flagStrobe |=> $stable(flagDevSel));
endmodule

bind mq_read_port mq_read_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .idCode     (idCode),
  .rdAddr     (rdAddr),
  .rdAddrEn   (rdAddrEn),
  .flagStrobe (flagStrobe),
  .rdData     (rdData),
  .rdValid    (rdValid),
  .outEnable  (outEnable),
  .flagDevSel (flagDevSel)
);

// File: tb/mq_read_port_tb.sv
`timescale 1ns/1ps
module mq_read_port_tb;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 16;
  localparam logic [2:0] MY_ID = 3'd3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [2:0]        idCode = MY_ID;
  logic [5:0]        rdAddr = '0;
  logic              rdAddrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic              flagStrobe = 1'b0;
  logic              wrEn = 1'b0;
  logic [2:0]        wrQueue = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              rdValid;
  logic              outEnable;
  logic [2:0]        flagDevSel;

  always #2.5 clk = ~clk;

  mq_read_port #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (.*);

  // Behavioural reference model
  logic [DATA_W-1:0] mq [8][$];
  int                mSelQ = 0, mPrevQ = 0, mStage = 0;
  bit                mSelV = 0, mPrevV = 0;
  logic [DATA_W-1:0] eData = '0;
  bit                eValid = 0;
  logic [2:0]        eFlag = '0;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    check(tag, "rdValid", 32'(rdValid), 32'(eValid));
    check(tag, "rdData", 32'(rdData), 32'(eData));
    check(tag, "outEnable", 32'(outEnable), 32'(mSelV));
    check(tag, "flagDevSel", 32'(flagDevSel), 32'(eFlag));
  endtask

  // One clock edge: the model uses the inputs held across the edge.
  task automatic tick(input string tag);
    bit act, useQ, popOk, pushOk;
    int q;
    @(posedge clk);
    act = 0; useQ = 1; q = mSelQ;
    if (mStage == 1) begin act = 1; useQ = mPrevV; q = mPrevQ; end
    else if (mStage == 2) begin act = 1; useQ = mSelV; end
    else act = mSelV && rdEn;
    popOk  = act && useQ && (mq[q].size() > 0);
    pushOk = wrEn && (mq[wrQueue].size() < DEPTH);
    if (act) begin
      if (popOk) begin eData = mq[q].pop_front(); eValid = 1; end
      else eValid = 0;
    end
    if (pushOk) mq[wrQueue].push_back(wrData);
    if (flagStrobe) eFlag = rdAddr[5:3];
    if (rdAddrEn) begin
      if (rdAddr[5:3] == idCode) begin
        mPrevQ = mSelQ; mPrevV = mSelV;
        mSelQ = int'(rdAddr[2:0]); mSelV = 1; mStage = 1;
      end else begin
        mSelV = 0; mStage = 0;
      end
    end else if (mStage == 1) mStage = 2;
    else mStage = 0;
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic load(input int q, input logic [DATA_W-1:0] d);
    wrEn = 1; wrQueue = 3'(q); wrData = d;
    tick("R10");
    wrEn = 0;
  endtask

  task automatic selectQ(input int dev, input int q, input bit ren, input string tag);
    rdAddrEn = 1; rdAddr = {3'(dev), 3'(q)}; rdEn = ren;
    tick(tag);
    rdAddrEn = 0; rdEn = 0;
  endtask

  task automatic readN(input int n, input string tag);
    rdEn = 1;
    for (int i = 0; i < n; i++) tick(tag);
    rdEn = 0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    compareAll("R1");
    rstN = 1;
    tick("R1");
    tick("R11");

    // R10: load two queues while deselected
    for (int i = 0; i < 5; i++) load(2, 16'hA200 + 16'(i));
    for (int i = 0; i < 3; i++) load(5, 16'hB500 + 16'(i));

    // R2, R6, R7: first select, no previous queue
    selectQ(3, 2, 0, "R2");
    tick("R6");
    tick("R7");
    tick("R11");
    tick("R11");
    readN(2, "R4");

    // R5, R6, R7: switch while reading
    selectQ(3, 5, 1, "R5");
    tick("R6");
    tick("R7");

    // R8: drain to empty and over-read, then refill
    readN(4, "R8");
    load(5, 16'hB5FF);
    readN(1, "R8");

    // R3: select another device, reads ignored
    selectQ(6, 1, 1, "R3");
    readN(3, "R3");
    load(2, 16'hA2EE);
    tick("R3");
    selectQ(3, 2, 0, "R2");
    tick("R6");
    tick("R7");

    // R9: flag strobe captures device field only
    flagStrobe = 1; rdAddr = 6'b101_111;
    tick("R9");
    rdAddr = 6'b000_010;
    tick("R9");
    flagStrobe = 0; rdAddr = 6'b110_001;
    tick("R9");

    // R10: overfill a queue, then read it all back
    for (int i = 0; i < DEPTH + 1; i++) load(7, 16'h7000 + 16'(i));
    selectQ(3, 7, 1, "R5");
    tick("R6");
    tick("R7");
    readN(DEPTH, "R10");
    tick("R11");

    finished = 1;
    report();
  end
endmodule